// File: doc/BRIEF.md
# Serial FIFO DMA Ready Handshake Controller

This block drives the two active-low DMA request lines of a serial controller with transmit and receive FIFOs of DEPTH entries (16 by default). It looks at the FIFO occupancy counts, the FIFO enable and DMA mode-select control bits, the two-bit receive trigger field, the character-timeout flag and the self-clearing clear pulses. From these it decides when a DMA engine should move received data out and when it should move transmit data in. It also gives the interrupt logic a flag that shows the receive trigger level has been reached.

There are two signalling modes. In single-transfer mode (mode 0) each line follows the occupancy directly. In block-transfer mode (mode 1) each line has hysteresis. The receive line asserts on trigger or timeout and holds until the receive FIFO is drained. The transmit line asserts on empty and holds until the transmit FIFO is full. Mode 1 is in force only when the FIFOs are enabled and the mode-select bit is set. The ready outputs are registered: each reflects the inputs sampled at the previous rising edge of `clk_i`.

Top module: `fifo_dma_ready`

## Requirements
- R1: While `rst_ni` is low, `rxrdy_no` and `txrdy_no` are both 1 (deasserted), whatever the other inputs are.
- R2: `trig_hit_o` is combinational and is 1 exactly when the effective receive count is at least the threshold. With FIFOs enabled, `trig_sel_i` values 0, 1, 2 and 3 give thresholds of 1, DEPTH/4, DEPTH/2 and DEPTH-2 (1, 4, 8, 14 for DEPTH 16).
- R3: With `fifo_en_i` low, mode 0 applies even if `dma_mode_i` is 1, and the trigger threshold is 1 whatever `trig_sel_i` holds.
- R4: In mode 0, `rxrdy_no` is 0 after an edge that samples a nonzero receive count, and 1 after an edge that samples a zero count.
- R5: In mode 1, `rxrdy_no` goes from 1 to 0 after an edge that samples a nonzero receive count together with either `trig_hit_o` or `char_timeout_i`. A count below the trigger with no timeout leaves it at 1. A timeout with an empty FIFO leaves it at 1.
- R6: In mode 1, once `rxrdy_no` is 0 it stays 0 while the sampled receive count is nonzero, even below the trigger level. It returns to 1 after an edge that samples a zero count.
- R7: In mode 0, `txrdy_no` is 0 after an edge that samples a zero transmit count, and 1 after an edge that samples any nonzero count.
- R8: In mode 1, `txrdy_no` goes to 0 after an edge that samples an empty transmit FIFO and stays 0 for partial counts. It goes to 1 after an edge that samples a count of DEPTH and stays 1 for partial counts until the FIFO is empty again.
- R9: While a clear pulse is high, its direction's count is taken as zero. `rx_clear_i` forces `trig_hit_o` low, and `rxrdy_no` is 1 after that edge. `tx_clear_i` makes `txrdy_no` 0 after that edge in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | FIFO enable control bit |
| dma_mode_i | input | 1 | DMA mode select (1 = block transfer when FIFOs enabled) |
| trig_sel_i | input | 2 | Receive trigger level select |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| char_timeout_i | input | 1 | Receive character-timeout flag |
| rx_clear_i | input | 1 | Receive FIFO clear pulse |
| tx_clear_i | input | 1 | Transmit FIFO clear pulse |
| rxrdy_no | output | 1 | Receive DMA ready, active low |
| txrdy_no | output | 1 | Transmit DMA ready, active low |
| trig_hit_o | output | 1 | Receive trigger level reached |

## Verification
The bench targets the hysteresis windows of mode 1: receive counts that fall below the trigger after assertion, and transmit counts that are partial on the way up and on the way down. A design that dropped the hold would release the receive line early or release the transmit line on the first load. It also enables DMA mode with the FIFOs off, where a design that ignored the enable would hold the lines in block mode or apply a 14-character trigger. Timeout on an empty FIFO, and clear pulses that arrive while the count inputs still show data, catch designs that let stale occupancy win over the clear or let the timeout assert an empty receiver.

// File: rtl/rdy_sig_pkg.sv
package rdy_sig_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'd0,
    TRIG_QTR  = 2'd1,
    TRIG_HALF = 2'd2,
    TRIG_NEAR = 2'd3
  } trig_sel_e;

  // receive trigger threshold for a given select code and FIFO depth
  function automatic int unsigned trig_level(logic [1:0] sel, int unsigned depth);
    case (trig_sel_e'(sel))
      TRIG_ONE:  return 1;
      TRIG_QTR:  return depth / 4;
      TRIG_HALF: return depth / 2;
      default:   return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/dma_trig_decode.sv
module dma_trig_decode #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  output logic             hit_o
);
  localparam int unsigned NUM_LVL = 4;

  logic [CNT_W-1:0] lvl_tab [NUM_LVL];
  logic [CNT_W-1:0] thr;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign lvl_tab[g] = CNT_W'(rdy_sig_pkg::trig_level(2'(g), DEPTH));
  end

  // depth-1 behaviour when FIFOs are off
  assign thr   = fifo_en_i ? lvl_tab[trig_sel_i] : CNT_W'(1);
  assign hit_o = (rx_cnt_i >= thr);

endmodule

// File: rtl/dma_rx_ready.sv
module dma_rx_ready #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode1_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             hit_i,
  input  logic             timeout_i,
  output logic             ready_o
);
  logic ready_q, ready_d;
  logic empty;

  assign empty = (cnt_i == '0);

  always_comb begin
    ready_d = ready_q;
    if (!mode1_i)                ready_d = !empty;
    else if (empty)              ready_d = 1'b0;
    else if (hit_i || timeout_i) ready_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= ready_d;
  end

  assign ready_o = ready_q;

endmodule

// File: rtl/dma_tx_ready.sv
module dma_tx_ready #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode1_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic ready_q, ready_d;
  logic empty, full;

  assign empty = (cnt_i == '0);
  assign full  = (cnt_i >= FULL);

  always_comb begin
    ready_d = ready_q;
    if (!mode1_i)   ready_d = empty;
    else if (empty) ready_d = 1'b1;
    else if (full)  ready_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= ready_d;
  end

  assign ready_o = ready_q;

endmodule

// File: rtl/fifo_dma_ready.sv
module fifo_dma_ready #(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             dma_mode_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             char_timeout_i,
  input  logic             rx_clear_i,
  input  logic             tx_clear_i,
  output logic             rxrdy_no,
  output logic             txrdy_no,
  output logic             trig_hit_o
);
  logic             mode1;
  logic [CNT_W-1:0] rx_eff, tx_eff;
  logic             rx_rdy, tx_rdy;

  assign mode1  = fifo_en_i && dma_mode_i;
  // a clear pulse means the FIFO is empty from this cycle on
  assign rx_eff = rx_clear_i ? '0 : rx_count_i;
  assign tx_eff = tx_clear_i ? '0 : tx_count_i;

  dma_trig_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
    .fifo_en_i (fifo_en_i),
    .trig_sel_i(trig_sel_i),
    .rx_cnt_i  (rx_eff),
    .hit_o     (trig_hit_o)
  );

  dma_rx_ready #(.CNT_W(CNT_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode1_i  (mode1),
    .cnt_i    (rx_eff),
    .hit_i    (trig_hit_o),
    .timeout_i(char_timeout_i),
    .ready_o  (rx_rdy)
  );

  dma_tx_ready #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode1_i(mode1),
    .cnt_i  (tx_eff),
    .ready_o(tx_rdy)
  );

  assign rxrdy_no = !rx_rdy;
  assign txrdy_no = !tx_rdy;

endmodule

// File: rtl/fifo_dma_ready_chk.sv
module fifo_dma_ready_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             dma_mode_i,
  input logic [CNT_W-1:0] rx_count_i,
  input logic [CNT_W-1:0] tx_count_i,
  input logic             rx_clear_i,
  input logic             tx_clear_i,
  input logic             rxrdy_no,
  input logic             txrdy_no,
  input logic             trig_hit_o
);
  logic m1;
  assign m1 = fifo_en_i && dma_mode_i;

  // R2
  trig_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_hit_o |-> (rx_count_i != '0 && !rx_clear_i));

  // R4
  rx_mode0_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1 && rx_count_i != '0 && !rx_clear_i) |=> !rxrdy_no);

  // R6
  rx_mode1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1 && !rxrdy_no && rx_count_i != '0 && !rx_clear_i) |=> !rxrdy_no);

  // R7
  tx_mode0_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1 && tx_count_i == '0) |=> !txrdy_no);

  // R8
  tx_mode1_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1 && !tx_clear_i && tx_count_i >= CNT_W'(DEPTH)) |=> txrdy_no);

  // R9
  rx_clear_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clear_i |=> rxrdy_no);

  // R9
  tx_clear_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_clear_i |=> !txrdy_no);

endmodule

bind fifo_dma_ready fifo_dma_ready_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fifo_en_i (fifo_en_i),
  .dma_mode_i(dma_mode_i),
  .rx_count_i(rx_count_i),
  .tx_count_i(tx_count_i),
  .rx_clear_i(rx_clear_i),
  .tx_clear_i(tx_clear_i),
  .rxrdy_no  (rxrdy_no),
  .txrdy_no  (txrdy_no),
  .trig_hit_o(trig_hit_o)
);

// File: tb/fifo_dma_ready_test.sv
`timescale 1ns/1ps
module fifo_dma_ready_test;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fifo_en, dma_mode, timeout, rx_clr, tx_clr;
  logic [1:0] tsel;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic rxrdy_n, txrdy_n, hit;

  int checks = 0;
  int fails = 0;
  bit m_rx = 1'b0;
  bit m_tx = 1'b0;

  always #4 clk = ~clk;

  fifo_dma_ready #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en), .dma_mode_i(dma_mode),
    .trig_sel_i(tsel), .rx_count_i(rx_cnt), .tx_count_i(tx_cnt),
    .char_timeout_i(timeout), .rx_clear_i(rx_clr), .tx_clear_i(tx_clr),
    .rxrdy_no(rxrdy_n), .txrdy_no(txrdy_n), .trig_hit_o(hit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl(input logic en, input logic [1:0] s);
    if (!en) return 1;
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  // one cycle: drive after a falling edge, check hit, clock, check ready lines
  task automatic step(input logic en, input logic dm, input logic [1:0] ts,
                      input int rc, input int tc, input logic to,
                      input logic rcl, input logic tcl);
    int  reff, teff;
    bit  m1, eh, prev_rx;
    string rtag, ttag;
    fifo_en = en; dma_mode = dm; tsel = ts; rx_cnt = CNT_W'(rc); tx_cnt = CNT_W'(tc);
    timeout = to; rx_clr = rcl; tx_clr = tcl;
    reff = rcl ? 0 : rc;
    teff = tcl ? 0 : tc;
    m1 = en && dm;
    eh = (reff >= lvl(en, ts));
    #1;
    chk(hit == eh, rcl ? "R9 hit" : (en ? "R2 hit" : "R3 hit"), hit, eh);
    prev_rx = m_rx;
    if (!m1) m_rx = (reff != 0);
    else if (reff == 0) m_rx = 1'b0;
    else if (eh || to) m_rx = 1'b1;
    if (!m1) m_tx = (teff == 0);
    else if (teff == 0) m_tx = 1'b1;
    else if (teff >= DEPTH) m_tx = 1'b0;
    rtag = rcl ? "R9 rx" : (!m1 ? (en ? "R4 rx" : "R3 rx") : (prev_rx ? "R6 rx" : "R5 rx"));
    ttag = tcl ? "R9 tx" : (!m1 ? (en ? "R7 tx" : "R3 tx") : "R8 tx");
    @(posedge clk);
    @(negedge clk);
    chk(rxrdy_n == !m_rx, rtag, rxrdy_n, !m_rx);
    chk(txrdy_n == !m_tx, ttag, txrdy_n, !m_tx);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1655;
    void'($urandom(seed));
    fifo_en = 1; dma_mode = 0; tsel = 0; rx_cnt = 5; tx_cnt = 0;
    timeout = 1; rx_clr = 0; tx_clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: inputs would assert both lines, reset keeps them high
    chk(rxrdy_n == 1'b1, "R1 rx", rxrdy_n, 1);
    chk(txrdy_n == 1'b1, "R1 tx", txrdy_n, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    m_rx = 1'b1; m_tx = 1'b1;
    step(1, 0, 0, 0, 0, 0, 0, 0);

    // R2: thresholds at and below each level
    for (int s = 0; s < 4; s++) begin
      step(1, 0, 2'(s), lvl(1, 2'(s)) - 1, 1, 0, 0, 0);
      step(1, 0, 2'(s), lvl(1, 2'(s)), 1, 0, 0, 0);
    end

    // R3: DMA bit set with FIFOs off behaves as mode 0, threshold 1
    step(0, 1, 3, 1, 0, 0, 0, 0);
    step(0, 1, 3, 0, 1, 0, 0, 0);
    step(0, 1, 3, 2, 3, 0, 0, 0);

    // R5/R6: mode 1 receive with trigger 8
    step(1, 1, 2, 0, 0, 0, 0, 0);
    step(1, 1, 2, 3, 0, 0, 0, 0);
    step(1, 1, 2, 8, 0, 0, 0, 0);
    step(1, 1, 2, 2, 0, 0, 0, 0);
    step(1, 1, 2, 1, 0, 0, 0, 0);
    step(1, 1, 2, 0, 0, 0, 0, 0);
    step(1, 1, 2, 0, 0, 1, 0, 0);
    step(1, 1, 2, 1, 0, 1, 0, 0);
    step(1, 1, 2, 1, 0, 0, 0, 0);

    // R8: mode 1 transmit hysteresis
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 5, 0, 0, 0);
    step(1, 1, 0, 0, 15, 0, 0, 0);
    step(1, 1, 0, 0, 16, 0, 0, 0);
    step(1, 1, 0, 0, 3, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);

    // R9: clears while the count inputs still show stale data
    step(1, 1, 0, 12, 16, 0, 0, 0);
    step(1, 1, 0, 12, 16, 1, 1, 1);
    step(1, 0, 0, 9, 9, 0, 1, 1);

    // R7: mode 0 transmit
    step(1, 0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic en, dm, to, rc, tc;
      int r, t;
      en = ($urandom % 4) != 0;
      dm = ($urandom % 3) != 0;
      r  = $urandom % (DEPTH + 1);
      t  = ($urandom % 4 == 0) ? DEPTH : $urandom % (DEPTH + 1);
      to = ($urandom % 8) == 0;
      rc = ($urandom % 16) == 0;
      tc = ($urandom % 16) == 0;
      step(en, dm, 2'($urandom % 4), r, t, to, rc, tc);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule